// File: doc/BRIEF.md
# Byte-Lane Controller for an External Asynchronous Static RAM

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 32 bits. The host issues one word operation at a time over a request/acknowledge port. Each operation carries a word address, a read/write flag, write data and a four-bit lane mask. The controller turns each operation into a correctly timed sequence on the memory pins: two chip enables of opposite polarity, output enable, write enable, four active-low byte strobes, the address bus and a split data bus (out, in, drive enable).

Every analog timing figure (access time, write pulse width, data setup, the margin between output enable rising and write enable falling, and the time before the memory may drive again after a write) is given in nanoseconds as a parameter. The figures are converted to whole clock-cycle counts at elaboration. A write pulse is sized by the longer of the pulse-width and data-setup counts. The pulse-width figure used depends on whether output enable stays asserted during writes. Write requests that arrive back to back are chained: write enable stays low and only the byte strobes frame each word.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, no chip enable, output enable, write enable or byte strobe is active, the data bus is not driven, and `ack` and `done` are low.
- R2: The memory is selected (`mem_ce_n`=0, `mem_ce2`=1) only while an operation or its turnaround is in progress. When idle it is deselected (`mem_ce_n`=1, `mem_ce2`=0).
- R3: A read holds the address with `mem_we_n` high and `mem_oe_n` low. It pulls `mem_bw_n[i]` low for each lane i whose mask bit is set, where lane i is data bits 8i+7 down to 8i. It samples the bus only after the address has been valid for at least the access-time count, plus one cycle. `rdata` carries zero in every lane whose mask bit is clear.
- R4: A write that does not continue a chain keeps `mem_oe_n` high for at least the OE-to-WE count before `mem_we_n` falls. Write enable and the selected strobes are then low together for N_PW cycles, where N_PW is the larger of the pulse-width count and the data-setup count.
- R5: A lane whose mask bit is clear is never strobed, so its memory byte keeps its old value. A write with an all-zero mask changes nothing.
- R6: Address and write data stay constant while any strobe is low and for one cycle after the strobes rise, and the bus is still driven in that cycle.
- R7: If a write request is present in the last pulse cycle of a write, `mem_we_n` stays low. The strobes rise for one cycle, the new address and data appear with strobes high, and the next pulse follows. A chained pair shows exactly one rising edge of `mem_we_n`.
- R8: The data bus is driven only while write enable is low or in the hold cycle, never while the memory may drive it. After it is released, at least the turnaround count of cycles passes before `mem_oe_n` falls.
- R9: `done` is a one-cycle pulse. It comes N_AA+1 cycles after a read is accepted, and N_OEW+N_PW+1 cycles after a write is accepted (1+N_PW+1 for a chained write).
- R10: A request is accepted (`ack`=1, combinational) only in idle, or in the hold cycle of a write that chains into it. A read issued during a write is accepted N_OEW+N_PW+N_LZ+2 cycles after that write, and a read following a read is accepted N_AA+2 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane mask, bit i selects bits 8i+7:8i |
| ack | output | 1 | Request accepted on this clock edge |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, masked lanes zero |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bw_n | output | DATA_W/8 | Byte strobes, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
With a 5 ns clock, the default counts are an access time of 2 cycles, a write pulse of 2 cycles, and one cycle each for the OE-to-WE margin and the turnaround. A read's `done` is therefore due 3 cycles after its accepting edge, and a write's `done` 4 cycles after it, chained or not. The scoreboard stores the accepting cycle with each expected item and compares it with the cycle in which `done` is seen. The memory model in the bench updates its bus on falling edges and counts how long the address has been steady. It returns a poison value until the access time has elapsed, so a premature sample shows up as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_SAMPLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } ctl_state_e;

    // Control intents, all active high; the top converts them to pin polarity.
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic strobe;
        logic drive;
    } pin_ctl_t;

    // Whole cycles covering a time in ns, never less than one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // The counter only ever moves down between loads.
    p_count_down_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned N_AA      = 2,
    parameter int unsigned N_OEW     = 1,
    parameter int unsigned N_PW      = 2,
    parameter int unsigned N_LZ      = 1,
    parameter bit          WR_OE_LOW = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  logic     req_we_i,
    output logic     accept_o,
    output logic     capture_o,
    output logic     done_o,
    output pin_ctl_t ctl_o
);
    localparam int unsigned MAXC  = max_u(max_u(N_AA, N_OEW), max_u(N_PW, N_LZ));
    localparam int unsigned CNT_W = $clog2(MAXC + 1);

    ctl_state_e       state_q, state_d;
    logic             chain_q, chain_d;
    logic             done_q, finish;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;

    sram_ctl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ld),
        .load_val_i (ld_val),
        .expired_o  (expired)
    );

    always_comb begin
        state_d   = state_q;
        chain_d   = chain_q;
        ld        = 1'b0;
        ld_val    = '0;
        accept_o  = 1'b0;
        capture_o = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    ld       = 1'b1;
                    if (req_we_i) begin
                        state_d = ST_WR_SETUP;
                        ld_val  = CNT_W'(N_OEW - 1);
                        chain_d = 1'b0;
                    end else begin
                        state_d = ST_RD_SETUP;
                        ld_val  = CNT_W'(N_AA - 1);
                    end
                end
            end
            ST_RD_SETUP: begin
                if (expired) state_d = ST_RD_SAMPLE;
            end
            ST_RD_SAMPLE: begin
                capture_o = 1'b1;
                finish    = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (expired) begin
                    state_d = ST_WR_PULSE;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(N_PW - 1);
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    state_d = ST_WR_HOLD;
                    chain_d = req_i && req_we_i;
                end
            end
            ST_WR_HOLD: begin
                finish = 1'b1;
                ld     = 1'b1;
                if (chain_q) begin
                    accept_o = 1'b1;
                    state_d  = ST_WR_SETUP;
                    ld_val   = '0;
                end else begin
                    state_d  = ST_TURN;
                    ld_val   = CNT_W'(N_LZ - 1);
                end
            end
            ST_TURN: begin
                if (expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chain_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            chain_q <= chain_d;
            done_q  <= finish;
        end
    end

    logic we_low;
    assign we_low = (state_q == ST_WR_PULSE) ||
                    (chain_q && (state_q == ST_WR_HOLD || state_q == ST_WR_SETUP));

    generate
        if (WR_OE_LOW) begin : g_oe_kept
            assign ctl_o.oe = (state_q == ST_RD_SETUP) || (state_q == ST_RD_SAMPLE) || we_low;
        end else begin : g_oe_raised
            assign ctl_o.oe = (state_q == ST_RD_SETUP) || (state_q == ST_RD_SAMPLE);
        end
    endgenerate

    assign ctl_o.sel    = (state_q != ST_IDLE);
    assign ctl_o.we     = we_low;
    assign ctl_o.strobe = (state_q == ST_RD_SETUP) || (state_q == ST_RD_SAMPLE) ||
                          (state_q == ST_WR_PULSE);
    assign ctl_o.drive  = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD) ||
                          (chain_q && state_q == ST_WR_SETUP);
    assign done_o       = done_q;

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: a request is never taken while strobes frame a transfer.
    p_ack_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> !ctl_o.strobe);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [DATA_W/8-1:0]  mask_i,
    input  logic                 strobe_i,
    input  logic                 drive_i,
    input  logic                 capture_i,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic [DATA_W/8-1:0]  bw_n_o,
    output logic [DATA_W-1:0]    dq_out_o,
    output logic                 dq_oe_o,
    input  logic [DATA_W-1:0]    dq_in_i,
    output logic [DATA_W-1:0]    rdata_o
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
            data_q <= wdata_i;
            mask_q <= mask_i;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bw_n_o[g] = ~(strobe_i & mask_q[g]);
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_q[g*8 +: 8] <= '0;
            end else if (capture_i) begin
                rdata_q[g*8 +: 8] <= mask_q[g] ? dq_in_i[g*8 +: 8] : 8'h00;
            end
        end
    end

    assign mem_addr_o = addr_q;
    assign dq_out_o   = data_q;
    assign dq_oe_o    = drive_i;
    assign rdata_o    = rdata_q;

    // R6: address steady across consecutive strobe cycles.
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && $past(strobe_i)) |-> $stable(mem_addr_o));

    // R6: one cycle of hold after a write strobe ends.
    p_write_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_i) && drive_i) |-> ($stable(mem_addr_o) && $stable(dq_out_o)));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CLK_NS      = 5,
    parameter int unsigned T_AA_NS     = 10,
    parameter int unsigned T_PWE_NS    = 8,
    parameter int unsigned T_PWE_OE_NS = 10,
    parameter int unsigned T_SD_NS     = 6,
    parameter int unsigned T_OE_WE_NS  = 4,
    parameter int unsigned T_LZWE_NS   = 2,
    parameter bit          WR_OE_LOW   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_mask,
    output logic                 ack,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_ce_n,
    output logic                 mem_ce2,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W/8-1:0]  mem_bw_n,
    output logic [DATA_W-1:0]    mem_dq_out,
    input  logic [DATA_W-1:0]    mem_dq_in,
    output logic                 mem_dq_oe
);
    localparam int unsigned N_AA   = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int unsigned N_OEW  = ns_to_cycles(T_OE_WE_NS, CLK_NS);
    localparam int unsigned N_LZ   = ns_to_cycles(T_LZWE_NS, CLK_NS);
    localparam int unsigned N_PWE  = ns_to_cycles(WR_OE_LOW ? T_PWE_OE_NS : T_PWE_NS, CLK_NS);
    localparam int unsigned N_PW   = max_u(N_PWE, ns_to_cycles(T_SD_NS, CLK_NS));
    localparam int unsigned GAP_SAT = 15;
    localparam int unsigned GAP_MIN = (N_LZ > GAP_SAT) ? GAP_SAT : N_LZ;

    pin_ctl_t ctl;
    logic     accept;
    logic     capture;

    sram_ctl_fsm #(
        .N_AA      (N_AA),
        .N_OEW     (N_OEW),
        .N_PW      (N_PW),
        .N_LZ      (N_LZ),
        .WR_OE_LOW (WR_OE_LOW)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .req_we_i  (req_we),
        .accept_o  (accept),
        .capture_o (capture),
        .done_o    (done),
        .ctl_o     (ctl)
    );

    sram_ctl_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_lanes (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .addr_i     (req_addr),
        .wdata_i    (req_wdata),
        .mask_i     (req_mask),
        .strobe_i   (ctl.strobe),
        .drive_i    (ctl.drive),
        .capture_i  (capture),
        .mem_addr_o (mem_addr),
        .bw_n_o     (mem_bw_n),
        .dq_out_o   (mem_dq_out),
        .dq_oe_o    (mem_dq_oe),
        .dq_in_i    (mem_dq_in),
        .rdata_o    (rdata)
    );

    assign ack      = accept;
    assign mem_ce_n = ~ctl.sel;
    assign mem_ce2  = ctl.sel;
    assign mem_oe_n = ~ctl.oe;
    assign mem_we_n = ~ctl.we;

    // Cycles since the controller last drove the bus (assertion support).
    logic [3:0] rel_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            rel_cnt <= 4'(GAP_SAT);
        end else if (mem_dq_oe) begin
            rel_cnt <= '0;
        end else if (rel_cnt != 4'(GAP_SAT)) begin
            rel_cnt <= rel_cnt + 1'b1;
        end
    end

    // R8: never drive while the memory's outputs may be enabled.
    p_no_contention_r8: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n || !mem_we_n));

    // R8: turnaround gap before a read enables the memory outputs.
    p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_oe_n) && mem_we_n) |-> (32'(rel_cnt) >= GAP_MIN));

    // R4: output enable already high when write enable falls.
    p_oe_before_we_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(mem_oe_n));

    // R2: the two chip enables always agree on selection.
    p_sel_agree_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && mem_ce2));

endmodule

// File: tb/test_sram_ctl.sv
`timescale 1ns/100ps
module test_sram_ctl;
    localparam real CLK_PERIOD = 5.0;
    localparam int  CLK_NS = 5;
    localparam int  AW = 19;
    localparam int  DW = 32;
    localparam int  NL = DW / 8;

    function automatic int cdiv(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int T_AA = 10;
    localparam int B_AA  = cdiv(T_AA, CLK_NS);
    localparam int B_OEW = cdiv(4, CLK_NS);
    localparam int B_LZ  = cdiv(2, CLK_NS);
    localparam int B_PW  = (cdiv(8, CLK_NS) > cdiv(6, CLK_NS)) ? cdiv(8, CLK_NS) : cdiv(6, CLK_NS);
    localparam int LAT_RD = B_AA + 1;
    localparam int LAT_WR = B_OEW + B_PW + 1;
    localparam int LAT_CH = 1 + B_PW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NL-1:0] req_mask = '0;
    logic ack, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [NL-1:0] mem_bw_n;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    sram_ctl #(.CLK_NS(CLK_NS)) i_sram_ctl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .ack(ack), .done(done),
        .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bw_n(mem_bw_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference memory and scoreboard ----------------
    logic [31:0] ref_mem [int];
    logic [31:0] mdl_mem [int];

    function automatic logic [31:0] rd_ref(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] rd_mdl(input int a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] lane_mask(input logic [NL-1:0] m);
        logic [31:0] r;
        for (int i = 0; i < NL; i++) r[i*8 +: 8] = m[i] ? 8'hFF : 8'h00;
        return r;
    endfunction

    typedef struct { bit rd; logic [31:0] exp; int acc; int lat; } sb_t;
    sb_t sbq[$];

    // Driver: presents a request and waits for acceptance; req stays high
    // until the caller issues another request or calls idle().
    task automatic op(input bit wr, input int a, input logic [31:0] d,
                      input logic [NL-1:0] m, input int lat, output int acc);
        sb_t it;
        @(negedge clk);
        req = 1'b1; req_we = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
        #1;
        while (!ack) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        it.rd = !wr; it.acc = acc; it.lat = lat;
        if (wr) begin
            ref_mem[a] = (rd_ref(a) & ~lane_mask(m)) | (d & lane_mask(m));
            it.exp = 32'h0;
        end else begin
            it.exp = rd_ref(a) & lane_mask(m);
        end
        sbq.push_back(it);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares completions with the queue.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 32'(cyc), 32'h0);
            end else begin
                sb_t it;
                it = sbq.pop_front();
                chk(cyc - it.acc == it.lat, "R9 done latency", 32'(cyc - it.acc), 32'(it.lat));
                if (it.rd) chk(rdata == it.exp, "R3 read data", rdata, it.exp);
            end
        end
    end

    // ---------------- behavioural memory with timing checks ----------------
    bit p_wact = 0, p_we_n = 1, p_oe_n = 1, p_drv = 0, stable_ok = 1;
    logic [NL-1:0] p_lanes = '0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    int wlen = 0, rel = 16, age = 0, we_rises = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_wact = 0; p_we_n = 1; p_oe_n = 1; p_drv = 0; stable_ok = 1;
            wlen = 0; rel = 16; age = 0;
        end else begin
            bit sel, wact, drv;
            logic [NL-1:0] wa;
            logic [31:0] word;
            sel = !mem_ce_n && mem_ce2;
            for (int i = 0; i < NL; i++) wa[i] = sel && !mem_we_n && !mem_bw_n[i];
            wact = |wa;
            if (wact) begin
                if (!mem_dq_oe) chk(1'b0, "R8 write without drive", 32'(mem_dq_oe), 32'h1);
                if (p_wact && (mem_addr != p_addr || mem_dq_out != p_data || wa != p_lanes))
                    stable_ok = 0;
                wlen++;
            end
            if (p_wact && !wact) begin
                chk(wlen >= B_PW, "R4 pulse length", 32'(wlen), 32'(B_PW));
                chk(stable_ok && mem_addr == p_addr && mem_dq_out == p_data && mem_dq_oe,
                    "R6 setup/hold", mem_dq_out, p_data);
                word = rd_mdl(int'(p_addr));
                for (int i = 0; i < NL; i++) if (p_lanes[i]) word[i*8 +: 8] = p_data[i*8 +: 8];
                mdl_mem[int'(p_addr)] = word;
                wlen = 0; stable_ok = 1;
            end
            if (sel && p_we_n && !mem_we_n) chk(p_oe_n, "R4 oe high before we", 32'(p_oe_n), 32'h1);
            if (!p_we_n && mem_we_n) we_rises++;
            drv = sel && !mem_oe_n && mem_we_n;
            if (drv && mem_dq_oe) chk(1'b0, "R8 bus contention", 32'(mem_dq_oe), 32'h0);
            if (sel && p_oe_n && !mem_oe_n) chk(rel >= B_LZ, "R8 turnaround", 32'(rel), 32'(B_LZ));
            rel = mem_dq_oe ? 0 : rel + 1;
            age = (drv && p_drv && mem_addr == p_addr) ? age + 1 : (drv ? 1 : 0);
            word = rd_mdl(int'(mem_addr));
            for (int i = 0; i < NL; i++) begin
                if (drv && !mem_bw_n[i])
                    mem_dq_in[i*8 +: 8] = ((age * CLK_NS * 2 - CLK_NS) >= 2 * T_AA) ? word[i*8 +: 8] : 8'hC3;
                else
                    mem_dq_in[i*8 +: 8] = 8'hEE;
            end
            p_wact = wact; p_lanes = wa; p_addr = mem_addr; p_data = mem_dq_out;
            p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_drv = drv;
        end
    end

    // ---------------- stimulus ----------------
    task automatic check_idle_pins(input string tag);
        chk(mem_ce_n == 1'b1 && mem_ce2 == 1'b0, {tag, " deselected"}, {30'h0, mem_ce_n, mem_ce2}, 32'h2);
        chk(mem_oe_n && mem_we_n && mem_bw_n == '1 && !mem_dq_oe, {tag, " strobes idle"},
            {26'h0, mem_oe_n, mem_we_n, mem_bw_n}, 32'h3F);
    endtask

    initial begin
        int a0, a1, a2;
        repeat (3) @(negedge clk);
        check_idle_pins("R1");
        chk(!done && !ack, "R1 handshake idle", {30'h0, done, ack}, 32'h0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check_idle_pins("R1 after reset");
        chk(!done, "R1 done low", 32'(done), 32'h0);

        // Full word write and read back.
        op(1, 'h10, 32'h1122_3344, 4'hF, LAT_WR, a0); idle();
        op(0, 'h10, 32'h0, 4'hF, LAT_RD, a1); idle();
        drain();
        check_idle_pins("R2 idle between operations");

        // Lane merging; R5.
        op(1, 'h20, 32'hAAAA_AAAA, 4'hF, LAT_WR, a0); idle();
        op(1, 'h20, 32'h1234_5655, 4'h1, LAT_WR, a0); idle();
        op(1, 'h20, 32'h9977_9999, 4'h4, LAT_WR, a0); idle();
        op(0, 'h20, 32'h0, 4'hF, LAT_RD, a1); idle();
        drain();
        chk(rd_mdl('h20) == 32'hAA77_AA55, "R5 lane merge in memory", rd_mdl('h20), 32'hAA77_AA55);

        // Empty mask writes nothing; R5.
        op(1, 'h10, 32'hFFFF_FFFF, 4'h0, LAT_WR, a0); idle();
        op(0, 'h10, 32'h0, 4'hF, LAT_RD, a1); idle();
        drain();
        chk(rd_mdl('h10) == 32'h1122_3344, "R5 empty mask", rd_mdl('h10), 32'h1122_3344);

        // Partial-lane read, unselected lanes zero; R3.
        op(0, 'h20, 32'h0, 4'h5, LAT_RD, a0); idle();
        drain();

        // Chained writes at the address extremes; R7.
        a2 = we_rises;
        op(1, 'h7FFFF, 32'hCAFE_F00D, 4'hF, LAT_WR, a0);
        op(1, 'h00000, 32'h0BAD_BEEF, 4'h3, LAT_CH, a1); idle();
        drain();
        chk(we_rises - a2 == 1, "R7 single we rise for chain", 32'(we_rises - a2), 32'h1);
        chk(a1 - a0 == B_OEW + B_PW + 1, "R7 chained acceptance", 32'(a1 - a0), 32'(B_OEW + B_PW + 1));
        op(0, 'h7FFFF, 32'h0, 4'hF, LAT_RD, a0); idle();
        op(0, 'h00000, 32'h0, 4'hF, LAT_RD, a0); idle();
        drain();

        // Three-word chain onto one address; R7 and R5.
        a2 = we_rises;
        op(1, 'h30, 32'h1111_1111, 4'hF, LAT_WR, a0);
        op(1, 'h30, 32'h4400_0000, 4'h8, LAT_CH, a0);
        op(1, 'h30, 32'h0000_2200, 4'h2, LAT_CH, a0); idle();
        drain();
        chk(we_rises - a2 == 1, "R7 triple chain one we rise", 32'(we_rises - a2), 32'h1);
        op(0, 'h30, 32'h0, 4'hF, LAT_RD, a0); idle();
        drain();

        // Read issued during a write and read after read; R10 and R8.
        op(1, 'h40, 32'h1234_5678, 4'hF, LAT_WR, a0);
        op(0, 'h40, 32'h0, 4'hF, LAT_RD, a1);
        op(0, 'h40, 32'h0, 4'hC, LAT_RD, a2); idle();
        drain();
        chk(a1 - a0 == B_OEW + B_PW + B_LZ + 2, "R10 read after write accepted",
            32'(a1 - a0), 32'(B_OEW + B_PW + B_LZ + 2));
        chk(a2 - a1 == B_AA + 2, "R10 read after read accepted", 32'(a2 - a1), 32'(B_AA + 2));
        check_idle_pins("R2 final idle");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 32'(cyc), 32'h0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule